// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block brings an Ethernet link up after reset with no processor involved. It talks to the PHY through a simple register request port, and a separate serial management master carries out each request on the wire. The sequence runs in a fixed order:

- Read the two PHY identifier registers and throw the values away.
- Read the basic status register repeatedly, with a programmable idle gap between reads, until auto-negotiation finishes, the PHY reports that it cannot negotiate, or the poll budget is used up.
- Decode the final status word into a speed output and a duplex output for the MAC.
- Write the PHY LED-control register to select traffic-meter mode.
- Raise `done`.

When negotiation cannot complete, the block uses a fallback status word that selects 10 Mb/s half duplex, and it raises `timed_out` together with `done`. The sequence starts by itself when reset is released. A `start` pulse stops whatever is in progress and runs the whole sequence again from the first identifier read.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset release or a `start` pulse, the block issues a read of register 2. Once that read completes, it issues a read of register 3. After that, every read goes to register 1. All three are reads (`mreq_write`=0), and the 5-bit register number appears on `mreq_addr`.
- R2: A request stays on `mreq_valid` with `mreq_addr`, `mreq_write` and `mreq_wdata` held steady until `mreq_ack` is seen in the same cycle. The cycle after that ack may start the next request. An `mreq_ack` that arrives while `mreq_valid` is low has no effect.
- R3: If a status read returns bit 3 clear (PHY cannot negotiate), polling stops at once. The fallback word 0x0800 (only bit 11 set) is used, and the block reports a timeout.
- R4: If a status read returns bit 3 set and bit 5 set (negotiation complete), polling stops and that status word is decoded.
- R5: At most MAX_POLLS status reads are issued per run. If the last allowed read still shows neither completion nor inability, the fallback word 0x0800 is used and a timeout is reported.
- R6: `link_100m` is 1 when bit 14 or bit 13 of the decoded word is set, and 0 otherwise (10 Mb/s).
- R7: `link_full_duplex` is 1 when bit 14 or bit 12 of the decoded word is set, and 0 otherwise (half duplex).
- R8: Between two status reads of the same run, `mreq_valid` is low for exactly `poll_gap` cycles. When `poll_gap` is 0, the reads follow one another with no gap.
- R9: After the speed and duplex are set, the block issues one write (`mreq_write`=1) to register 0x1B with data 0x0040 (only bit 6 set). No other write is ever issued.
- R10: `done` rises in the cycle after the LED write is acknowledged, and then holds with no request outstanding until the next `start`. `timed_out` is 1 only together with `done`, and only for a run that used the fallback word.
- R11: A `start` pulse, sampled at a clock edge, clears `done` and `timed_out` on that edge and restarts the sequence at R1, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that restarts the sequence |
| poll_gap | input | GAP_W | Idle cycles between consecutive status reads |
| mreq_valid | output | 1 | Management request pending |
| mreq_write | output | 1 | 1 = register write, 0 = register read |
| mreq_addr | output | 5 | PHY register number |
| mreq_wdata | output | 16 | Write data (zero for reads) |
| mreq_ack | input | 1 | Request completed; read data valid this cycle |
| mreq_rdata | input | 16 | Read data returned with the ack |
| link_100m | output | 1 | MAC speed select, 1 = 100 Mb/s |
| link_full_duplex | output | 1 | MAC duplex select, 1 = full duplex |
| done | output | 1 | Bring-up sequence finished |
| timed_out | output | 1 | Finished using the 10 Mb/s half-duplex fallback |

## Verification
The bench targets these corner cases:

- **Status word with completion set but ability clear.** A design that checks the completion bit first would take that word as valid instead of falling back.
- **Exhausted poll budget.** An off-by-one counter would issue one read too many or one too few.
- **Gap of zero against a gap of several cycles.** A wrong gap timer would stretch the back-to-back case or shorten the spaced case.
- **Completed status word that decodes to 10 Mb/s half duplex.** This run must leave `timed_out` low, so a design that confuses it with the fallback is caught.
- **Restart in the middle of polling.** A design that fails to flush its state would skip the identifier reads or carry over the poll count.
- **Stray ack after `done`.** A design that does not qualify the ack with its own request would change state.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_ID_HI,
    ST_ID_LO,
    ST_POLL,
    ST_GAP,
    ST_LED,
    ST_DONE
  } lbs_state_e;

  localparam int          ADDR_W        = 5;
  localparam int          DATA_W        = 16;

  localparam logic [4:0]  REG_STATUS    = 5'd1;
  localparam logic [4:0]  REG_ID_HI     = 5'd2;
  localparam logic [4:0]  REG_ID_LO     = 5'd3;
  localparam logic [4:0]  REG_LED_CTRL  = 5'h1B;

  localparam logic [15:0] LED_TRAFFIC   = 16'h0040;
  localparam logic [15:0] STAT_FALLBACK = 16'h0800;

  localparam int BIT_CAN_NEG  = 3;
  localparam int BIT_NEG_DONE = 5;
  localparam int BIT_10_FD    = 12;
  localparam int BIT_100_HD   = 13;
  localparam int BIT_100_FD   = 14;

endpackage

// File: rtl/lbs_rst_sync.sv
module lbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lbs_poll_budget.sv
module lbs_poll_budget #(
  parameter int MAX_POLLS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/lbs_gap_timer.sv
module lbs_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [GAP_W-1:0] gap,
  output logic             expire
);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? gap : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q == GAP_W'(1));

endmodule

// File: rtl/lbs_link_decode.sv
module lbs_link_decode
  import lbs_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  output logic              speed_100,
  output logic              full_duplex
);

  always_comb begin
    speed_100   = word[BIT_100_FD] | word[BIT_100_HD];
    full_duplex = word[BIT_100_FD] | word[BIT_10_FD];
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int MAX_POLLS = 10000,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] poll_gap,
  output logic             mreq_valid,
  output logic             mreq_write,
  output logic [4:0]       mreq_addr,
  output logic [15:0]      mreq_wdata,
  input  logic             mreq_ack,
  input  logic [15:0]      mreq_rdata,
  output logic             link_100m,
  output logic             link_full_duplex,
  output logic             done,
  output logic             timed_out
);

  logic rst_ni;

  lbs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  lbs_state_e state_q, state_d;

  logic ack_ok;
  logic finish;
  logic fb_hit;
  logic budget_clr, budget_inc, budget_last;
  logic gap_load, gap_run, gap_expire;

  logic [DATA_W-1:0] final_word;
  logic              dec_100, dec_fd;

  logic spd_q, fd_q, done_q, to_q, fb_q;
  logic spd_d, fd_d, done_d, to_d, fb_d;
  logic cfg_en, flag_en;

  lbs_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (budget_clr),
    .inc   (budget_inc),
    .last  (budget_last)
  );

  lbs_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_ni),
    .load   (gap_load),
    .run    (gap_run),
    .gap    (poll_gap),
    .expire (gap_expire)
  );

  lbs_link_decode u_dec (
    .word        (final_word),
    .speed_100   (dec_100),
    .full_duplex (dec_fd)
  );

  // Request port driven from the state register
  always_comb begin
    mreq_valid = 1'b0;
    mreq_write = 1'b0;
    mreq_addr  = '0;
    mreq_wdata = '0;
    unique case (state_q)
      ST_ID_HI: begin mreq_valid = 1'b1; mreq_addr = REG_ID_HI; end
      ST_ID_LO: begin mreq_valid = 1'b1; mreq_addr = REG_ID_LO; end
      ST_POLL:  begin mreq_valid = 1'b1; mreq_addr = REG_STATUS; end
      ST_LED: begin
        mreq_valid = 1'b1;
        mreq_write = 1'b1;
        mreq_addr  = REG_LED_CTRL;
        mreq_wdata = LED_TRAFFIC;
      end
      default: ;
    endcase
  end

  assign ack_ok  = mreq_valid & mreq_ack;
  assign gap_run = (state_q == ST_GAP);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    finish     = 1'b0;
    fb_hit     = 1'b0;
    budget_clr = 1'b0;
    budget_inc = 1'b0;
    gap_load   = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        state_d    = ST_ID_HI;
        budget_clr = 1'b1;
      end
      ST_ID_HI: if (ack_ok) state_d = ST_ID_LO;
      ST_ID_LO: if (ack_ok) state_d = ST_POLL;
      ST_POLL: begin
        if (ack_ok) begin
          if (!mreq_rdata[BIT_CAN_NEG]) begin
            finish = 1'b1;
            fb_hit = 1'b1;
          end else if (mreq_rdata[BIT_NEG_DONE]) begin
            finish = 1'b1;
          end else if (budget_last) begin
            finish = 1'b1;
            fb_hit = 1'b1;
          end else begin
            budget_inc = 1'b1;
            if (poll_gap != '0) begin
              gap_load = 1'b1;
              state_d  = ST_GAP;
            end
          end
          if (finish) state_d = ST_LED;
        end
      end
      ST_GAP:  if (gap_expire) state_d = ST_POLL;
      ST_LED:  if (ack_ok) state_d = ST_DONE;
      ST_DONE: ;
      default: state_d = ST_BOOT;
    endcase
    if (start) begin
      state_d    = ST_ID_HI;
      budget_clr = 1'b1;
      budget_inc = 1'b0;
      gap_load   = 1'b0;
      finish     = 1'b0;
      fb_hit     = 1'b0;
    end
  end

  assign final_word = fb_hit ? STAT_FALLBACK : mreq_rdata;

  // Configuration and status flag next values
  always_comb begin
    cfg_en  = finish;
    spd_d   = dec_100;
    fd_d    = dec_fd;
    flag_en = start | finish | (state_q == ST_LED && ack_ok);
    fb_d    = fb_q;
    done_d  = done_q;
    to_d    = to_q;
    if (start) begin
      fb_d   = 1'b0;
      done_d = 1'b0;
      to_d   = 1'b0;
    end else if (finish) begin
      fb_d   = fb_hit;
    end else begin
      done_d = 1'b1;
      to_d   = fb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BOOT;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_q <= 1'b0;
      fd_q  <= 1'b0;
    end else if (cfg_en) begin
      spd_q <= spd_d;
      fd_q  <= fd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q   <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else if (flag_en) begin
      fb_q   <= fb_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign link_100m        = spd_q;
  assign link_full_duplex = fd_q;
  assign done             = done_q;
  assign timed_out        = to_q;

endmodule

// File: rtl/lbs_seq_checker.sv
module lbs_seq_checker #(
  parameter int MAX_POLLS = 10000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mreq_valid,
  input logic        mreq_write,
  input logic [4:0]  mreq_addr,
  input logic [15:0] mreq_wdata,
  input logic        mreq_ack,
  input logic        link_100m,
  input logic        link_full_duplex,
  input logic        done,
  input logic        timed_out
);

  localparam int PW = $clog2(MAX_POLLS + 2) + 1;

  logic [PW-1:0] polls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) polls_q <= '0;
    else if (start) polls_q <= '0;
    else if (mreq_valid && mreq_ack && !mreq_write && mreq_addr == 5'd1)
      polls_q <= polls_q + 1'b1;
  end

  assert_id_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_ack && !start && mreq_addr == 5'd2
    |=> mreq_valid && mreq_addr == 5'd3 && !mreq_write);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ack && !start
    |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_write) && $stable(mreq_wdata));

  assert_fallback_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !link_100m && !link_full_duplex);

  assert_poll_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= PW'(MAX_POLLS));

  assert_led_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_write |-> mreq_addr == 5'h1B && mreq_wdata == 16'h0040);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mreq_valid);

  assert_timeout_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> done);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start
    |=> done && $stable(link_100m) && $stable(link_full_duplex) && $stable(timed_out));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !timed_out && mreq_valid && mreq_addr == 5'd2 && !mreq_write);

endmodule

bind link_bringup_seq lbs_seq_checker #(.MAX_POLLS(MAX_POLLS)) u_seq_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .start            (start),
  .mreq_valid       (mreq_valid),
  .mreq_write       (mreq_write),
  .mreq_addr        (mreq_addr),
  .mreq_wdata       (mreq_wdata),
  .mreq_ack         (mreq_ack),
  .link_100m        (link_100m),
  .link_full_duplex (link_full_duplex),
  .done             (done),
  .timed_out        (timed_out)
);

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;

  localparam int MAXP  = 12;
  localparam int GAP_W = 8;
  localparam int LAT   = 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [GAP_W-1:0] poll_gap;
  logic             mreq_valid, mreq_write;
  logic [4:0]       mreq_addr;
  logic [15:0]      mreq_wdata;
  logic             mreq_ack;
  logic [15:0]      mreq_rdata;
  logic             link_100m, link_full_duplex, done, timed_out;

  always #10 clk = ~clk;

  link_bringup_seq #(.MAX_POLLS(MAXP), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_gap(poll_gap),
    .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_addr(mreq_addr),
    .mreq_wdata(mreq_wdata), .mreq_ack(mreq_ack), .mreq_rdata(mreq_rdata),
    .link_100m(link_100m), .link_full_duplex(link_full_duplex),
    .done(done), .timed_out(timed_out)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [21:0] exp_q[$];
  logic [15:0] stat_q[$];
  bit          hold = 1'b1;
  bit          spurious = 1'b0;
  bit          prev_poll = 1'b0;
  int          lowcnt = 0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [21:0] pack_req(input bit wr, input logic [4:0] a,
                                           input logic [15:0] d);
    return {wr, a, d};
  endfunction

  // PHY-side responder and scoreboard monitor
  initial begin : responder
    int wcnt = 0;
    mreq_ack   = 1'b0;
    mreq_rdata = '0;
    forever begin
      @(negedge clk);
      mreq_ack = 1'b0;
      if (spurious) begin
        mreq_ack = 1'b1;
      end else if (!hold && mreq_valid) begin
        if (wcnt == LAT) begin
          logic [21:0] got, want;
          string tag;
          wcnt = 0;
          mreq_ack = 1'b1;
          got = pack_req(mreq_write, mreq_addr, mreq_wdata);
          if (exp_q.size() == 0) begin
            check(1'b0, "R5", "request beyond expected sequence", int'(got), 0);
          end else begin
            want = exp_q.pop_front();
            tag = want[21] ? "R9" : (want[20:16] == 5'd1 ? "R5" : "R1");
            check(got == want, tag, "request {wr,addr,data}", int'(got), int'(want));
          end
          if (!mreq_write && mreq_addr == 5'd1) begin
            if (prev_poll)
              check(lowcnt == int'(poll_gap), "R8", "idle cycles between polls",
                    lowcnt, int'(poll_gap));
            prev_poll  = 1'b1;
            mreq_rdata = (stat_q.size() != 0) ? stat_q.pop_front() : 16'h7809;
          end else begin
            prev_poll  = 1'b0;
            mreq_rdata = (mreq_addr == 5'd2) ? 16'h0143 : 16'hBC72;
          end
          lowcnt = 0;
        end else begin
          wcnt++;
        end
      end else if (!mreq_valid) begin
        lowcnt++;
        wcnt = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R10", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic prep();
    hold = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.delete();
    stat_q.delete();
    prev_poll = 1'b0;
    lowcnt = 0;
  endtask

  task automatic launch(input bit do_start, input int gap, input int npolls);
    poll_gap = GAP_W'(gap);
    if (do_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!done && !timed_out, "R11", "flags after start", {done, timed_out}, 0);
      check(mreq_valid && mreq_addr == 5'd2 && !mreq_write, "R11",
            "first request after start", {mreq_valid, mreq_addr}, {1'b1, 5'd2});
    end
    exp_q.push_back(pack_req(1'b0, 5'd2, 16'h0));
    exp_q.push_back(pack_req(1'b0, 5'd3, 16'h0));
    for (int i = 0; i < npolls; i++) exp_q.push_back(pack_req(1'b0, 5'd1, 16'h0));
    exp_q.push_back(pack_req(1'b1, 5'h1B, 16'h0040));
    prev_poll = 1'b0;
    lowcnt = 0;
    hold = 1'b0;
  endtask

  task automatic finish_case(input bit e100, input bit efd, input bit eto, input string tag);
    int guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R10", "done reached", done, 1);
    check(exp_q.size() == 0, "R5", "outstanding expected requests", exp_q.size(), 0);
    check(link_100m == e100, "R6", {tag, " speed"}, link_100m, e100);
    check(link_full_duplex == efd, "R7", {tag, " duplex"}, link_full_duplex, efd);
    check(timed_out == eto, "R3", {tag, " timed_out"}, timed_out, eto);
    repeat (4) @(negedge clk);
    check(done && !mreq_valid, "R10", "done held, no request", {done, mreq_valid}, 2);
  endtask

  initial begin : driver
    rst_n    = 1'b0;
    start    = 1'b0;
    poll_gap = '0;
    repeat (3) @(negedge clk);
    check(!mreq_valid && !done && !timed_out && !link_100m && !link_full_duplex,
          "R1", "reset state", {mreq_valid, done, timed_out, link_100m, link_full_duplex}, 0);
    // Case A: automatic run after reset, gap 2, completes on fourth poll -> 100 FD
    stat_q.push_back(16'h7809);
    stat_q.push_back(16'h7809);
    stat_q.push_back(16'h7809);
    stat_q.push_back(16'h782D);
    rst_n = 1'b1;
    launch(1'b0, 2, 4);
    finish_case(1'b1, 1'b1, 1'b0, "R4 caseA");

    // Stray ack while done: must change nothing (R2)
    spurious = 1'b1;
    repeat (3) @(negedge clk);
    spurious = 1'b0;
    repeat (2) @(negedge clk);
    check(done && !mreq_valid && link_100m && link_full_duplex, "R2",
          "stray ack ignored", {done, mreq_valid, link_100m, link_full_duplex}, 4'b1011);

    // Case B: back-to-back polls, complete -> 10 FD
    prep();
    stat_q.push_back(16'h7809);
    stat_q.push_back(16'h1028);
    launch(1'b1, 0, 2);
    finish_case(1'b0, 1'b1, 1'b0, "R8 caseB");

    // Case C: 100 HD
    prep();
    stat_q.push_back(16'h2028);
    launch(1'b1, 1, 1);
    finish_case(1'b1, 1'b0, 1'b0, "R6 caseC");

    // Case D: completion bit set but cannot negotiate -> fallback
    prep();
    stat_q.push_back(16'h7820);
    launch(1'b1, 1, 1);
    finish_case(1'b0, 1'b0, 1'b1, "R3 caseD");

    // Case E: budget exhausted -> fallback after MAXP polls
    prep();
    launch(1'b1, 1, MAXP);
    finish_case(1'b0, 1'b0, 1'b1, "R5 caseE");

    // Case G: completed 10 HD is not a timeout
    prep();
    stat_q.push_back(16'h0828);
    launch(1'b1, 3, 1);
    finish_case(1'b0, 1'b0, 1'b0, "R4 caseG");

    // Case F: restart in the middle of polling
    prep();
    launch(1'b1, 3, MAXP);
    repeat (20) @(negedge clk);
    check(!done && mreq_addr == 5'd1 || !mreq_valid, "R11", "run in progress", done, 0);
    prep();
    stat_q.push_back(16'h4028);
    launch(1'b1, 0, 1);
    finish_case(1'b1, 1'b1, 1'b0, "R11 caseF");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule